// File: doc/BRIEF.md
# Counter-Compare Watchdog Timer

This block is a watchdog whose timeout comes from a comparison, not from a down-counter. A 16-bit counter runs all the time. It is split into a low byte and a high byte, and it advances once per tick of a selectable clock source. Software kicks the watchdog by writing the kick address. On that write the hardware stores a compare offset equal to the counter's high byte plus an 8-bit reload value, modulo 256.

The watchdog requests a reset when the low byte wraps from 0xFF while the high byte equals the stored offset. A kick therefore buys 256 × reload + (256 − low byte at the kick) ticks. Software can also force an immediate request through a flag write.

A small register port sets up the block. It holds enable, a sticky lock, the clock-source code, an idle-suspend bit and the reload value. The clock source and idle behaviour are frozen while the watchdog is enabled.

Top module: `cmpwdt_top`

## Requirements
- R1: After reset, `mode_o` reads enable=1, lock=0, clock code 0 and idle-suspend 0, `reload_o` is 0, the counter is 0 and `wdt_rst` is 0.
- R2: A write to address 2 is a kick, and its data is ignored. It stores offset = (counter high byte + reload) mod 256. Let L be the low byte just before the write edge. The next request then comes exactly 256 × reload + 256 − L ticks after that edge, provided the watchdog is enabled from the following cycle on.
- R3: A timeout request comes only from a low-byte wrap while the high byte equals the stored offset. `wdt_rst` is a one-cycle pulse, and the counter reads zero in the cycle the pulse is high.
- R4: A write to address 3 with data bit 0 set, while enabled, raises `wdt_rst` in the next cycle.
- R5: While disabled, neither a match nor a flag write produces a request, and the counter keeps running.
- R6: The mode register is at address 0, with bit 0 = enable and bit 1 = lock. Lock is set-only until reset. Setting lock also sets enable. Enable cannot be cleared while lock is set. Without lock, writing enable=0 disables the watchdog.
- R7: The clock code (mode bits 4:2) and idle-suspend (mode bit 5) take a write only if the watchdog was disabled before that write.
- R8: The clock codes are: 0 = system clock/12; 1 = system clock/4; 2 = one tick per system-clock cycle in which `ext_tick` is high; 3 = every system clock. Codes 4–7 behave as code 0. The reload register is at address 1.
- R9: With idle-suspend set, the counter holds while `cpu_idle` is high, and it resumes when `cpu_idle` falls.
- R10: With no writes after reset, the first request comes 3072 system-clock cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_idle | input | 1 | CPU idle indication |
| ext_tick | input | 1 | External tick, one system-clock cycle per event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 mode, 1 reload, 2 kick, 3 flag |
| wr_data | input | 8 | Register write data |
| wdt_rst | output | 1 | One-cycle reset request |
| cnt_lo | output | 8 | Counter low byte |
| cnt_hi | output | 8 | Counter high byte |
| mode_o | output | 8 | Mode register: bit 0 enable, 1 lock, 4:2 clock code, 5 idle-suspend |
| reload_o | output | 8 | Reload register |

## Verification
A register write takes effect at the clock edge that samples it, so the mode, reload and offset values can be read half a cycle later. A forced request shows on `wdt_rst` one edge after the flag write. A timeout shows exactly N edges after the kick edge, where N = 256 × reload + 256 − L ticks; with the undivided clock, ticks and edges are the same. The bench drives inputs and reads outputs on falling edges. It counts edges from the kick and compares the edge on which the pulse is first seen with the N it computes from L read just before the kick. Rate checks use windows that are whole multiples of the divider, so the prescaler phase cannot change the expected count.

// File: rtl/cmpwdt_pkg.sv
package cmpwdt_pkg;

  typedef enum logic [2:0] {
    CS_DIV_SLOW = 3'd0,
    CS_DIV_FAST = 3'd1,
    CS_EXT      = 3'd2,
    CS_SYS      = 3'd3
  } clksel_e;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       idle_sus;
    logic [2:0] clksel;
    logic       lock;
    logic       en;
  } mode_t;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_KICK   = 2'd2;
  localparam logic [1:0] ADDR_FLAG   = 2'd3;

  localparam mode_t MODE_RESET = '{rsvd: 2'b00, idle_sus: 1'b0,
                                   clksel: 3'd0, lock: 1'b0, en: 1'b1};

endpackage

// File: rtl/cmpwdt_prescale.sv
module cmpwdt_prescale
  import cmpwdt_pkg::*;
#(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] clksel,
  input  logic       ext_tick,
  output logic       tick
);
  localparam int PRE_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV_SLOW - 1);

  logic [PRE_W-1:0] pre_q;
  logic             slow_hit;
  logic             fast_hit;

  // one phase counter serves both divide ratios (DIV_SLOW is a multiple of DIV_FAST)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (run) begin
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end
  end

  function automatic logic f_fast_hit(input logic [PRE_W-1:0] p);
    return ((int'(p) % DIV_FAST) == (DIV_FAST - 1));
  endfunction

  assign slow_hit = (pre_q == PRE_LAST);
  assign fast_hit = f_fast_hit(pre_q);

  always_comb begin
    tick = 1'b0;
    if (run) begin
      case (clksel_e'(clksel))
        CS_DIV_FAST: tick = fast_hit;
        CS_EXT:      tick = ext_tick;
        CS_SYS:      tick = 1'b1;
        default:     tick = slow_hit;
      endcase
    end
  end

  // R9: a suspended source never ticks
  p_no_tick_suspended_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

endmodule

// File: rtl/cmpwdt_counter.sv
module cmpwdt_counter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clear,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              lo_wrap
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lo      = cnt_q[BYTE_W-1:0];
  assign hi      = cnt_q[CNT_W-1:BYTE_W];
  assign lo_wrap = tick && (&lo);

  // R8: the count moves only on a tick or a clear
  p_hold_without_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/cmpwdt_ctrl.sv
module cmpwdt_ctrl
  import cmpwdt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              lo_wrap,
  input  logic [BYTE_W-1:0] cnt_hi,
  output mode_t             mode,
  output logic [BYTE_W-1:0] reload,
  output logic              fire,
  output logic              wdt_rst
);
  logic [BYTE_W-1:0] offset_q;
  mode_t             wr_mode;
  logic              wr_mode_ev;
  logic              kick_ev;
  logic              force_ev;
  logic              match_ev;

  function automatic logic [BYTE_W-1:0] f_next_offset(input logic [BYTE_W-1:0] h,
                                                      input logic [BYTE_W-1:0] r);
    return h + r;
  endfunction

  assign wr_mode    = mode_t'(wr_data[7:0]);
  assign wr_mode_ev = wr_en && (wr_addr == ADDR_MODE);
  assign kick_ev    = wr_en && (wr_addr == ADDR_KICK);
  assign force_ev   = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];
  assign match_ev   = lo_wrap && (cnt_hi == offset_q);
  assign fire       = mode.en && (force_ev || match_ev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_RESET;
    end else if (wr_mode_ev) begin
      mode.lock <= mode.lock | wr_mode.lock;
      mode.en   <= mode.lock | wr_mode.lock | wr_mode.en;
      if (!mode.en) begin
        mode.clksel   <= wr_mode.clksel;
        mode.idle_sus <= wr_mode.idle_sus;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload <= '0;
    end else if (wr_en && (wr_addr == ADDR_RELOAD)) begin
      reload <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset_q <= '0;
    end else if (kick_ev) begin
      offset_q <= f_next_offset(cnt_hi, reload);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= fire;
    end
  end

  // R6: lock is sticky and keeps the watchdog enabled
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode.lock |=> (mode.lock && mode.en));
  // R7: protected fields stay put while enabled
  p_protect_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode.en |=> ($stable(mode.clksel) && $stable(mode.idle_sus)));
  // R5: a request always follows a cycle in which the watchdog was enabled
  p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(mode.en));
  // R4: an enabled flag write always produces a request
  p_force_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ev && mode.en) |=> wdt_rst);

endmodule

// File: rtl/cmpwdt_top.sv
module cmpwdt_top
  import cmpwdt_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_idle,
  input  logic              ext_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wdt_rst,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [7:0]        mode_o,
  output logic [BYTE_W-1:0] reload_o
);
  mode_t mode;
  logic  run;
  logic  tick;
  logic  lo_wrap;
  logic  fire;

  assign run    = !(mode.idle_sus && cpu_idle);
  assign mode_o = mode;

  cmpwdt_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clksel   (mode.clksel),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  cmpwdt_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clear   (fire),
    .lo      (cnt_lo),
    .hi      (cnt_hi),
    .lo_wrap (lo_wrap)
  );

  cmpwdt_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lo_wrap (lo_wrap),
    .cnt_hi  (cnt_hi),
    .mode    (mode),
    .reload  (reload_o),
    .fire    (fire),
    .wdt_rst (wdt_rst)
  );

  // R3: the counter is zero while the request pulse is high
  p_pulse_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> ((cnt_lo == '0) && (cnt_hi == '0)));
  // R3: a timeout pulse is not followed by a second one unless forced
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst && !(wr_en && wr_addr == ADDR_FLAG)) |=> !wdt_rst);

endmodule

// File: tb/cmpwdt_top_tb_top.sv
module cmpwdt_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_idle = 1'b0;
  logic       ext_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       wdt_rst;
  logic [7:0] cnt_lo, cnt_hi, mode_o, reload_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  cmpwdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_idle(cpu_idle), .ext_tick(ext_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wdt_rst(wdt_rst),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .mode_o(mode_o), .reload_o(reload_o)
  );

  // {reload, wait cycles before kick}
  localparam logic [15:0] VEC [4] = '{16'h0000, 16'h0105, 16'h0364, 16'h02FA};

  function automatic logic [7:0] md(input bit en, input bit lk, input int cs, input bit idl);
    return {2'b00, idl, cs[2:0], lk, en};
  endfunction

  function automatic int cnt16();
    return {cnt_hi, cnt_lo};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int k, lo0, exp_n, c0, pulses;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_o, 8'h01);
    chk("R1 reload", reload_o, 0);
    chk("R1 count", cnt16(), 0);
    chk("R1 wdt_rst", wdt_rst, 0);
    rst_n = 1'b1;
    // R10 default timeout: 256 ticks of sysclk/12
    k = 0;
    while (k < 4000) begin
      @(negedge clk); k++;
      if (wdt_rst) break;
    end
    chk("R10 default timeout cycles", k, 3072);
    chk("R3 count zero at pulse", cnt16(), 0);
    @(negedge clk);
    chk("R3 single cycle pulse", wdt_rst, 0);

    // R2 vector table: kick timing with undivided clock
    foreach (VEC[i]) begin
      wr(2'd0, md(0, 0, 3, 0));
      wr(2'd0, md(0, 0, 3, 0));
      wr(2'd1, VEC[i][15:8]);
      repeat (int'(VEC[i][7:0])) @(negedge clk);
      while (VEC[i][15:8] == 8'd0 && cnt_lo >= 8'd250) @(negedge clk);
      lo0   = cnt_lo;
      exp_n = (int'(VEC[i][15:8]) << 8) + 256 - lo0;
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h5A;
      k = 0;
      while (k < 1500) begin
        @(negedge clk); k++;
        if (k == 1) begin wr_addr = 2'd0; wr_data = md(1, 0, 3, 0); end
        if (k == 2) wr_en = 1'b0;
        if (wdt_rst) break;
      end
      wr_en = 1'b0;
      chk($sformatf("R2 timeout vec%0d", i), k, exp_n);
      chk($sformatf("R3 cleared vec%0d", i), cnt16(), 0);
    end

    // R7 protection while enabled (clock code 3 active)
    wr(2'd0, md(1, 0, 1, 1));
    chk("R7 clksel and idle frozen", mode_o, md(1, 0, 3, 0));

    // R4 forced request while enabled
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 forced pulse", wdt_rst, 1);
    chk("R4 counter cleared", cnt16(), 0);
    @(negedge clk);
    chk("R4 pulse one cycle", wdt_rst, 0);

    // R5 disabled: no match or forced request, counter runs
    wr(2'd0, md(0, 0, 3, 0));
    chk("R6 enable cleared", mode_o[0], 0);
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd0);
    c0 = cnt16(); pulses = 0;
    repeat (600) begin @(negedge clk); if (wdt_rst) pulses++; end
    wr(2'd3, 8'h01);
    repeat (3) begin @(negedge clk); if (wdt_rst) pulses++; end
    chk("R5 no pulses when disabled", pulses, 0);
    chk("R5 counter runs", (cnt16() - c0) & 16'hFFFF, 600 + 3 + 2);

    // R8 divide by 4
    wr(2'd0, md(0, 0, 1, 0));
    c0 = cnt16();
    repeat (40) @(negedge clk);
    chk("R8 div4 rate", (cnt16() - c0) & 16'hFFFF, 10);
    // R8 unused code falls back to divide by 12
    wr(2'd0, md(0, 0, 5, 0));
    c0 = cnt16();
    repeat (48) @(negedge clk);
    chk("R8 code5 rate", (cnt16() - c0) & 16'hFFFF, 4);
    // R8 external tick
    wr(2'd0, md(0, 0, 2, 0));
    c0 = cnt16();
    repeat (5) begin
      ext_tick = 1'b1; @(negedge clk);
      ext_tick = 1'b0; repeat (3) @(negedge clk);
    end
    chk("R8 ext tick count", (cnt16() - c0) & 16'hFFFF, 5);

    // R9 idle suspend
    wr(2'd0, md(0, 0, 3, 1));
    cpu_idle = 1'b1;
    c0 = cnt16();
    repeat (20) @(negedge clk);
    chk("R9 held while idle", cnt16(), c0);
    cpu_idle = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 resumes", (cnt16() - c0) & 16'hFFFF, 10);

    // R6 lock
    wr(2'd0, md(0, 1, 3, 0));
    chk("R6 lock sets enable", mode_o[1:0], 3);
    wr(2'd0, md(0, 0, 3, 0));
    chk("R6 lock holds enable", mode_o[1:0], 3);
    do_reset();
    @(negedge clk);
    chk("R1 lock cleared by reset", mode_o, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule